// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

This block holds two count channels, numbered 0 and 1, each built from a low byte and a high byte. A channel advances either once per machine-cycle strobe (`tick`) or once per detected falling edge on its external count pin. A channel only runs when its run bit is set and, if its gate bit is set, its gate pin is high. Each channel selects one of four count shapes: a 13-bit counter, a 16-bit counter, an 8-bit counter that reloads from the high byte, or a split shape.

In the split shape, channel 0 becomes two independent 8-bit counters. Its low byte keeps channel 0's run bit and flag. Its high byte counts machine cycles under channel 1's run bit and raises channel 1's flag. A channel 1 placed in the split shape holds its count.

Each channel has an overflow flag. The flag is set when the count wraps to zero, or reloads in the reload shape. An interrupt acknowledge clears it. Channel 1 also gives a one-cycle overflow strobe for a baud-rate generator.

Software loads the configuration byte, the control byte and the four count bytes through simple write strobes. All state resets synchronously on an active-high `rst`.

Top module: `dual_timer_counter`

## Requirements
- R1: After reset all four count bytes, both flags and the channel 1 strobe are 0.
- R2: In timer operation a running channel advances by exactly one per `tick` cycle and holds in cycles without `tick`.
- R3: In counter operation the count pin is sampled on each `tick`. The count advances on the second `tick` after the pin goes from 1 to 0. A pin that stays at one level adds nothing.
- R4: A channel advances only when its run bit is 1 and either its gate bit is 0 or its `gate_pin` bit is 1.
- R5: Shape 0 counts 13 bits, made of the high byte and the low 5 bits of the low byte. The top 3 bits of the low byte stay unchanged. The wrap from 1FFFh to 0 sets the flag.
- R6: Shape 1 counts 16 bits {high, low}. The wrap from FFFFh to 0 sets the flag.
- R7: Shape 2 counts in the low byte only. When the low byte steps past FFh it takes the high byte's value and sets the flag. The high byte never changes.
- R8: When channel 0 is in shape 3, its low byte counts under run bit 0 and sets flag 0. Its high byte counts `tick`s under run bit 1 and sets flag 1. A channel 1 in shape 3 holds its count.
- R9: `irq_ack[n]` clears flag n. An overflow in the same cycle wins, so the flag stays 1.
- R10: `t1_ovf_pulse` is high for the one cycle after each channel 1 overflow, including in shape 2. While channel 0 is split, channel 1 runs without its run bit and still pulses, but does not touch flag 1.
- R11: Write encodings:
  - `cfg_wdata` carries a nibble {gate, counter-select, shape[1:0]} per channel, with channel 1 in bits 7:4.
  - `ctl_wdata` bit 7 loads flag 1, bit 6 is run 1, bit 5 loads flag 0 and bit 4 is run 0.
  - `cnt_sel` 0/1/2/3 selects the channel 0 low, channel 0 high, channel 1 low and channel 1 high byte.
  - A count write overrides an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Machine-cycle strobe |
| cnt_pin | input | 2 | External count pins, bit n for channel n |
| gate_pin | input | 2 | Gate pins, bit n for channel n |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration byte |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte |
| cnt_we | input | 1 | Count byte write strobe |
| cnt_sel | input | 2 | Count byte select |
| cnt_wdata | input | BW | Count byte data |
| irq_ack | input | 2 | Flag clear per channel |
| tl0 | output | BW | Channel 0 low byte |
| th0 | output | BW | Channel 0 high byte |
| tl1 | output | BW | Channel 1 low byte |
| th1 | output | BW | Channel 1 high byte |
| ovf_flag | output | 2 | Overflow flags |
| t1_ovf_pulse | output | 1 | One-cycle channel 1 overflow strobe |

## Verification
The bench checks the carry from bit 4 into the high byte in the 13-bit shape. A design that counted through all 8 low bits would show 00h instead of E0h after the wrap.

It checks the reload, where the low byte must take the high byte's value rather than 00h. It checks the one-tick delay of edge detection; a design that counted on the first sample would lead by one.

In the split shape it checks that flag 1 is raised by channel 0's high byte and not by channel 1. The bench also covers the race between an acknowledge and a new overflow: a design that let the clear win would lose an interrupt.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    M_13BIT   = 2'd0,
    M_16BIT   = 2'd1,
    M_RELOAD8 = 2'd2,
    M_SPLIT   = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      cnt_sel;
    tmr_mode_e mode;
  } tmr_cfg_t;
endpackage

// File: rtl/tmr_event.sv
module tmr_event (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic pin,
  input  logic run,
  input  logic ext_sel,
  output logic step
);
  logic smp_now, smp_old;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_now <= 1'b0;
      smp_old <= 1'b0;
    end else if (tick) begin
      smp_old <= smp_now;
      smp_now <= pin;
    end
  end

  always_comb step = tick & run & (ext_sel ? (smp_old & ~smp_now) : 1'b1);

  // R3: an edge yields at most one count, never two in a row
  p_edge_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    (ext_sel && step) |=> !(ext_sel && step));
endmodule

// File: rtl/tmr_count_unit.sv
module tmr_count_unit
  import tmr_pkg::*;
#(
  parameter int BW   = 8,
  parameter int LO13 = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  tmr_mode_e     mode,
  input  logic          inc_lo,
  input  logic          inc_hi,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] tl,
  output logic [BW-1:0] th,
  output logic          ovf_lo,
  output logic          ovf_hi
);
  localparam int W13 = BW + LO13;
  localparam int W16 = 2 * BW;
  localparam logic [BW-1:0]  ONE8  = 1;
  localparam logic [W13-1:0] ONE13 = 1;
  localparam logic [W16-1:0] ONE16 = 1;

  logic [BW-1:0]  tl_d, th_d;
  logic [W13-1:0] short_q;
  logic           blk;

  assign short_q = {th, tl[LO13-1:0]};
  assign blk     = wr_lo | wr_hi;

  always_comb begin
    tl_d   = tl;
    th_d   = th;
    ovf_lo = 1'b0;
    ovf_hi = 1'b0;
    case (mode)
      M_13BIT: if (inc_lo && !blk) begin
        ovf_lo = &short_q;
        {th_d, tl_d[LO13-1:0]} = short_q + ONE13;
      end
      M_16BIT: if (inc_lo && !blk) begin
        ovf_lo = &{th, tl};
        {th_d, tl_d} = {th, tl} + ONE16;
      end
      M_RELOAD8: if (inc_lo && !blk) begin
        if (&tl) begin
          tl_d   = th;
          ovf_lo = 1'b1;
        end else begin
          tl_d = tl + ONE8;
        end
      end
      default: begin
        if (inc_lo && !wr_lo) begin
          ovf_lo = &tl;
          tl_d   = tl + ONE8;
        end
        if (inc_hi && !wr_hi) begin
          ovf_hi = &th;
          th_d   = th + ONE8;
        end
      end
    endcase
    if (wr_lo) tl_d = wdata;
    if (wr_hi) th_d = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tl <= '0;
      th <= '0;
    end else begin
      tl <= tl_d;
      th <= th_d;
    end
  end

  // R2: no step and no write leaves both bytes alone
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!inc_lo && !inc_hi && !wr_lo && !wr_hi) |=> (tl == $past(tl) && th == $past(th)));
  // R5: the top bits of the low byte stay out of the 13-bit count
  p_m0_top_bits_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == M_13BIT && !wr_lo) |=> tl[BW-1:LO13] == $past(tl[BW-1:LO13]));
  // R7: the reload source is never changed by counting
  p_reload_src_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == M_RELOAD8 && !wr_hi) |=> th == $past(th));
  // R6: a 16-bit overflow leaves zero behind
  p_wrap_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (ovf_lo && mode == M_16BIT) |=> (tl == '0 && th == '0));
endmodule

// File: rtl/dual_timer_counter.sv
module dual_timer_counter
  import tmr_pkg::*;
#(
  parameter int BW   = 8,
  parameter int LO13 = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [1:0]    cnt_pin,
  input  logic [1:0]    gate_pin,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_wdata,
  input  logic          cnt_we,
  input  logic [1:0]    cnt_sel,
  input  logic [BW-1:0] cnt_wdata,
  input  logic [1:0]    irq_ack,
  output logic [BW-1:0] tl0,
  output logic [BW-1:0] th0,
  output logic [BW-1:0] tl1,
  output logic [BW-1:0] th1,
  output logic [1:0]    ovf_flag,
  output logic          t1_ovf_pulse
);
  localparam int NCH = 2;

  tmr_cfg_t      cfg [NCH];
  logic [NCH-1:0] tr, run, step, inc_lo, inc_hi, ovf_lo, ovf_hi, set_flag;
  logic [BW-1:0] tl_w [NCH];
  logic [BW-1:0] th_w [NCH];
  logic          split;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg[0] <= '0;
      cfg[1] <= '0;
      tr     <= '0;
    end else begin
      if (cfg_we) begin
        cfg[0] <= tmr_cfg_t'(cfg_wdata[3:0]);
        cfg[1] <= tmr_cfg_t'(cfg_wdata[7:4]);
      end
      if (ctl_we) tr <= {ctl_wdata[6], ctl_wdata[4]};
    end
  end

  assign split = (cfg[0].mode == M_SPLIT);

  always_comb begin
    run[0]   = tr[0] & (~cfg[0].gate | gate_pin[0]);
    run[1]   = (split ? 1'b1 : tr[1]) & (~cfg[1].gate | gate_pin[1]);
    inc_lo[0] = step[0];
    inc_hi[0] = tick & tr[1] & split;
    inc_lo[1] = step[1] & (cfg[1].mode != M_SPLIT);
    inc_hi[1] = 1'b0;
    set_flag[0] = ovf_lo[0];
    set_flag[1] = split ? ovf_hi[0] : (ovf_lo[1] | ovf_hi[1]);
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [1:0] LO_SEL = 2'(2 * g);
    localparam logic [1:0] HI_SEL = 2'(2 * g + 1);

    tmr_event u_ev (
      .clk(clk), .rst(rst), .tick(tick), .pin(cnt_pin[g]),
      .run(run[g]), .ext_sel(cfg[g].cnt_sel), .step(step[g])
    );

    tmr_count_unit #(.BW(BW), .LO13(LO13)) u_cnt (
      .clk(clk), .rst(rst), .mode(cfg[g].mode),
      .inc_lo(inc_lo[g]), .inc_hi(inc_hi[g]),
      .wr_lo(cnt_we && cnt_sel == LO_SEL),
      .wr_hi(cnt_we && cnt_sel == HI_SEL),
      .wdata(cnt_wdata), .tl(tl_w[g]), .th(th_w[g]),
      .ovf_lo(ovf_lo[g]), .ovf_hi(ovf_hi[g])
    );
  end

  assign tl0 = tl_w[0];
  assign th0 = th_w[0];
  assign tl1 = tl_w[1];
  assign th1 = th_w[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag     <= '0;
      t1_ovf_pulse <= 1'b0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (set_flag[i])      ovf_flag[i] <= 1'b1;
        else if (irq_ack[i])  ovf_flag[i] <= 1'b0;
        else if (ctl_we)      ovf_flag[i] <= ctl_wdata[5 + 2 * i];
      end
      t1_ovf_pulse <= ovf_lo[1];
    end
  end

  // R9: an acknowledge with no new overflow clears the flag
  p_ack_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (irq_ack[0] && !ovf_lo[0]) |=> !ovf_flag[0]);
  // R9: an overflow always leaves the flag set
  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    ovf_lo[0] |=> ovf_flag[0]);
  // R8: channel 1 in the split shape keeps its count
  p_t1_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg[1].mode == M_SPLIT && !(cnt_we && cnt_sel[1])) |=> ($stable(tl1) && $stable(th1)));
  // R10: outside the split shape a channel 1 strobe comes with flag 1
  p_pulse_flag_r10: assert property (@(posedge clk) disable iff (rst)
    (t1_ovf_pulse && !$past(split)) |-> ovf_flag[1]);
  // R4: channel 0 with its run bit clear does not move
  p_stopped_r4: assert property (@(posedge clk) disable iff (rst)
    (!tr[0] && !split && !(cnt_we && !cnt_sel[1])) |=> ($stable(tl0) && $stable(th0)));
endmodule

// File: tb/tb_dual_timer_counter.sv
module tb_dual_timer_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [1:0] cnt_pin = 2'b11;
  logic [1:0] gate_pin = 2'b00;
  logic       cfg_we = 1'b0, ctl_we = 1'b0, cnt_we = 1'b0;
  logic [7:0] cfg_wdata = '0, ctl_wdata = '0, cnt_wdata = '0;
  logic [1:0] cnt_sel = '0, irq_ack = '0;
  logic [7:0] tl0, th0, tl1, th1;
  logic [1:0] ovf_flag;
  logic       t1_ovf_pulse;
  int         total = 0, fails = 0;

  always #2 clk = ~clk;

  dual_timer_counter dut (
    .clk(clk), .rst(rst), .tick(tick), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .cnt_we(cnt_we), .cnt_sel(cnt_sel), .cnt_wdata(cnt_wdata), .irq_ack(irq_ack),
    .tl0(tl0), .th0(th0), .tl1(tl1), .th1(th1),
    .ovf_flag(ovf_flag), .t1_ovf_pulse(t1_ovf_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v; @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic set_ctl(input logic [7:0] v);
    ctl_we = 1'b1; ctl_wdata = v; @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic set_cnt(input logic [1:0] s, input logic [7:0] v);
    cnt_we = 1'b1; cnt_sel = s; cnt_wdata = v; @(negedge clk); cnt_we = 1'b0;
  endtask

  task automatic ack(input logic [1:0] m);
    irq_ack = m; @(negedge clk); irq_ack = 2'b00;
  endtask

  task automatic t_reset;
    chk("R1 counts", {tl0, th0, tl1, th1}, 32'h0);
    chk("R1 flags", {ovf_flag, t1_ovf_pulse}, 3'b000);
  endtask

  task automatic t_mode16;
    set_cfg(8'h01); set_cnt(2'd0, 8'hFD); set_cnt(2'd1, 8'hFF); set_ctl(8'h10);
    do_tick(2);
    chk("R2 two ticks", {th0, tl0}, 16'hFFFF);
    chk("R6 no flag yet", ovf_flag[0], 1'b0);
    idle(3);
    chk("R2 hold without tick", {th0, tl0}, 16'hFFFF);
    do_tick(1);
    chk("R6 wrap", {th0, tl0}, 16'h0000);
    chk("R6 flag", ovf_flag[0], 1'b1);
    ack(2'b01);
    chk("R9 ack clears", ovf_flag[0], 1'b0);
    do_tick(3);
    chk("R2 three ticks", {th0, tl0}, 16'h0003);
  endtask

  task automatic t_gate;
    set_ctl(8'h00); set_cnt(2'd0, 8'h00); set_cnt(2'd1, 8'h00);
    set_cfg(8'h09); set_ctl(8'h10);
    gate_pin[0] = 1'b0;
    do_tick(4);
    chk("R4 gate low blocks", {th0, tl0}, 16'h0000);
    gate_pin[0] = 1'b1;
    do_tick(4);
    chk("R4 gate high runs", {th0, tl0}, 16'h0004);
    set_ctl(8'h00);
    do_tick(2);
    chk("R4 run bit clear stops", {th0, tl0}, 16'h0004);
    gate_pin[0] = 1'b0;
  endtask

  task automatic t_mode13;
    set_cfg(8'h00); set_cnt(2'd0, 8'hFE); set_cnt(2'd1, 8'hFF); set_ctl(8'h10);
    do_tick(1);
    chk("R5 step", {th0, tl0}, 16'hFFFF);
    do_tick(1);
    chk("R5 wrap keeps top bits", {th0, tl0}, 16'h00E0);
    chk("R5 flag", ovf_flag[0], 1'b1);
    ack(2'b01);
  endtask

  task automatic t_reload;
    set_ctl(8'h00); set_cfg(8'h02); set_cnt(2'd0, 8'hFE); set_cnt(2'd1, 8'h50); set_ctl(8'h10);
    do_tick(1);
    chk("R7 step", tl0, 8'hFF);
    do_tick(1);
    chk("R7 reload", {th0, tl0}, 16'h5050);
    chk("R7 flag", ovf_flag[0], 1'b1);
    do_tick(1);
    chk("R7 after reload", {th0, tl0}, 16'h5051);
    ack(2'b01);
  endtask

  task automatic t_counter;
    set_ctl(8'h00); set_cfg(8'h05); set_cnt(2'd0, 8'h00); set_cnt(2'd1, 8'h00);
    cnt_pin[0] = 1'b1; set_ctl(8'h10);
    do_tick(2);
    chk("R3 steady high", {th0, tl0}, 16'h0000);
    cnt_pin[0] = 1'b0;
    do_tick(1);
    chk("R3 first sample low", {th0, tl0}, 16'h0000);
    do_tick(1);
    chk("R3 second tick counts", {th0, tl0}, 16'h0001);
    do_tick(2);
    chk("R3 steady low", {th0, tl0}, 16'h0001);
    cnt_pin[0] = 1'b1; do_tick(1);
    cnt_pin[0] = 1'b0; do_tick(2);
    chk("R3 second edge", {th0, tl0}, 16'h0002);
    cnt_pin[0] = 1'b1;
  endtask

  task automatic t_split;
    set_ctl(8'h00); set_cfg(8'h33);
    set_cnt(2'd2, 8'h12); set_cnt(2'd3, 8'h34); set_cnt(2'd0, 8'hFF); set_cnt(2'd1, 8'hFE);
    set_ctl(8'h50);
    do_tick(1);
    chk("R8 low byte wraps", {th0, tl0}, 16'hFF00);
    chk("R8 flags after low wrap", ovf_flag, 2'b01);
    do_tick(1);
    chk("R8 high byte wraps", {th0, tl0}, 16'h0001);
    chk("R8 flag 1 from high byte", ovf_flag, 2'b11);
    chk("R8 channel 1 holds", {th1, tl1}, 16'h3412);
    set_ctl(8'h10);
    chk("R11 control write clears flags", ovf_flag, 2'b00);
    do_tick(1);
    chk("R8 high byte needs run 1", {th0, tl0}, 16'h0002);
  endtask

  task automatic t_pulse;
    set_ctl(8'h00); set_cfg(8'h20); set_cnt(2'd2, 8'hFE); set_cnt(2'd3, 8'hFE); set_ctl(8'h40);
    do_tick(1);
    chk("R10 no pulse yet", {tl1, 7'd0, t1_ovf_pulse}, {8'hFF, 8'h00});
    do_tick(1);
    chk("R10 reload and pulse", {tl1, 7'd0, t1_ovf_pulse}, {8'hFE, 8'h01});
    chk("R10 flag 1", ovf_flag[1], 1'b1);
    idle(1);
    chk("R10 pulse is one cycle", t1_ovf_pulse, 1'b0);
    set_ctl(8'h00); set_cfg(8'h23); set_cnt(2'd2, 8'hFF); set_cnt(2'd3, 8'h80);
    do_tick(1);
    chk("R10 split: channel 1 reloads", tl1, 8'h80);
    chk("R10 split: pulse", t1_ovf_pulse, 1'b1);
    chk("R10 split: flag 1 untouched", ovf_flag[1], 1'b0);
  endtask

  task automatic t_writes;
    set_ctl(8'h00); set_cfg(8'h01); set_cnt(2'd0, 8'h00); set_cnt(2'd1, 8'h00); set_ctl(8'h10);
    tick = 1'b1; cnt_we = 1'b1; cnt_sel = 2'd0; cnt_wdata = 8'h77;
    @(negedge clk);
    tick = 1'b0; cnt_we = 1'b0;
    chk("R11 write beats increment", {th0, tl0}, 16'h0077);
    do_tick(1);
    chk("R11 counts on from written value", {th0, tl0}, 16'h0078);
    set_ctl(8'h30);
    chk("R11 software sets flag 0", ovf_flag, 2'b01);
    set_ctl(8'h10); set_cnt(2'd0, 8'hFF); set_cnt(2'd1, 8'hFF);
    tick = 1'b1; irq_ack = 2'b01;
    @(negedge clk);
    tick = 1'b0; irq_ack = 2'b00;
    chk("R9 overflow beats acknowledge", ovf_flag[0], 1'b1);
    chk("R9 count wrapped", {th0, tl0}, 16'h0000);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", total, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_mode16();
    t_gate();
    t_mode13();
    t_reload();
    t_counter();
    t_split();
    t_pulse();
    t_writes();
    summary();
    $finish;
  end
endmodule